// File: doc/BRIEF.md
# Per-Locality Interrupt Controller

This block keeps a 32-bit interrupt-enable register and a 32-bit interrupt-status register for each of five localities. It receives event pulses tagged with a locality number. Each pulse carries a small set of source flags: data ready, status valid, locality changed and command ready. An event is latched into that locality's status only where the locality has enabled it. Any latched event raises one interrupt line that all localities share.

Software reaches the registers through a 32-bit port with byte lanes. Writes are taken only from the locality that currently owns the interface. Status bits are acknowledged by writing ones. The shared line stays raised until the owning locality clears its status to zero. The output polarity follows the owning locality's polarity field. A third register returns a fixed interrupt vector number.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset every enable register reads 0x0000_0008 (polarity field bits [4:3] = 1, low level), every status register reads 0, `reg_rvalid` is 0 and `irq_pin` is 1 (inactive, low-level).
- R2: An event with `evt_loc` below 5 sets that locality's status bits to `evt_bits` AND its enable bits, limited to the source bits 0 (data ready), 1 (status valid), 2 (locality changed) and 7 (command ready), when enable bit 31 (global enable) is 1. If at least one bit is set, the internal line level goes high and `irq_pin` shows this one clock later.
- R3: An event changes nothing in these cases: global enable is 0, no source bit matches, or `evt_loc` is 5 or more.
- R4: A write to the enable register (`reg_sel` = 0) replaces only the byte lanes selected by `reg_be`. Within those lanes it keeps only bits 31, 4, 3, 7, 2, 1 and 0 and zeroes the others. Unselected lanes keep their old value.
- R5: A write to the status register (`reg_sel` = 2) clears the source bits written as 1 within the selected byte lanes. All other bits are unchanged.
- R6: Enable and status writes whose `reg_loc` differs from `active_loc` are ignored. So is any write while `active_loc` is 5 or more.
- R7: The line level drops only after a status write by the active locality that leaves that locality's status at zero. It stays high if bits remain. If an event is latched in the same cycle as such a write, the line stays high and the new bits survive.
- R8: `irq_pin` equals the line level when bit 3 of the active locality's enable register is 0, and its inverse when that bit is 1. With no active locality, `irq_pin` is the inverse of the level.
- R9: A read of the vector register (`reg_sel` = 1) returns the parameter `VEC_NUM` (0 to 15). Writes to it have no effect. `reg_sel` = 3, or a `reg_loc` of 5 or more, reads 0.
- R10: A read pulse on `reg_rd` gives `reg_rvalid` = 1 on the next cycle, with `reg_rdata` holding the register value from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event pulse |
| evt_loc | input | 3 | Locality the event belongs to |
| evt_bits | input | 8 | Event source flags, status bit positions |
| active_loc | input | 3 | Locality that owns the interface (5..7: none) |
| reg_rd | input | 1 | Register read pulse |
| reg_wr | input | 1 | Register write pulse |
| reg_loc | input | 3 | Locality issuing the access |
| reg_sel | input | 2 | 0 enable, 1 vector, 2 status, 3 unused |
| reg_be | input | 4 | Byte-lane enables of a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid |
| irq_pin | output | 1 | Shared interrupt line, registered |

## Verification
An event can be latched in the same cycle as an acknowledging status write to the same locality. That cycle decides both the status contents and whether the line stays up. The bench drives an event and a clearing write together in one clock. It expects the cleared bits to be gone, the new bit to be present and the line to stay asserted. A second pairing issues a status read alongside a clearing write; the bench expects the read to return the value from before the write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W = 32;
  localparam int EVT_W = 8;
  localparam int GIE_BIT = 31;
  localparam int POL_LSB = 3;
  // source flags: data ready, status valid, locality changed, command ready
  localparam logic [REG_W-1:0] SRC_MASK  = 32'h0000_0087;
  // global enable, polarity field and source flags
  localparam logic [REG_W-1:0] KEEP_MASK = 32'h8000_009F;
  localparam logic [REG_W-1:0] EN_RESET  = 32'h0000_0008;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_VECTOR = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  function automatic logic [REG_W-1:0] lane_mask(input logic [REG_W/8-1:0] be);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W / 8; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/irqc_slot.sv
module irqc_slot
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_hit,
  input  logic [EVT_W-1:0] ev_bits,
  input  logic             en_wr,
  input  logic             st_wr,
  input  logic [REG_W-1:0] wmask,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] st_q,
  output logic [REG_W-1:0] en_nx,
  output logic             latched,
  output logic             st_nx_zero
);
  logic [REG_W-1:0] set_bits;
  logic [REG_W-1:0] clr_bits;
  logic [REG_W-1:0] st_nx;

  always_comb begin
    set_bits = '0;
    if (ev_hit && en_q[GIE_BIT])
      set_bits = {{(REG_W-EVT_W){1'b0}}, ev_bits} & en_q & SRC_MASK;
    latched  = |set_bits;
    clr_bits = st_wr ? (wdata & wmask & SRC_MASK) : '0;
    st_nx    = (st_q & ~clr_bits) | set_bits;
    st_nx_zero = (st_nx == '0);
    en_nx    = en_wr ? ((en_q & ~wmask) | (wdata & wmask & KEEP_MASK)) : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= EN_RESET;
      st_q <= '0;
    end else begin
      en_q <= en_nx;
      st_q <= st_nx;
    end
  end
endmodule

// File: rtl/irqc_regport.sv
module irqc_regport
  import irqc_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int VEC_NUM = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_rd,
  input  logic                          reg_wr,
  input  logic [LOC_W-1:0]              reg_loc,
  input  logic [1:0]                    reg_sel,
  input  logic [REG_W/8-1:0]            reg_be,
  input  logic [LOC_W-1:0]              active_loc,
  input  logic [NUM_LOC-1:0][REG_W-1:0] en_all,
  input  logic [NUM_LOC-1:0][REG_W-1:0] st_all,
  output logic [NUM_LOC-1:0]            en_wr_vec,
  output logic [NUM_LOC-1:0]            st_wr_vec,
  output logic [REG_W-1:0]              wmask,
  output logic [REG_W-1:0]              rdata,
  output logic                          rvalid
);
  localparam logic [LOC_W:0] LOC_LIM = (LOC_W+1)'(NUM_LOC);

  logic act_ok, loc_ok, wr_ok;
  logic [REG_W-1:0] rd_word;

  assign act_ok = ({1'b0, active_loc} < LOC_LIM);
  assign loc_ok = ({1'b0, reg_loc} < LOC_LIM);
  assign wr_ok  = reg_wr && act_ok && (reg_loc == active_loc);
  assign wmask  = lane_mask(reg_be);

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_dec
    assign en_wr_vec[i] = wr_ok && (reg_sel == SEL_ENABLE) && (reg_loc == LOC_W'(i));
    assign st_wr_vec[i] = wr_ok && (reg_sel == SEL_STATUS) && (reg_loc == LOC_W'(i));
  end

  always_comb begin
    rd_word = '0;
    if (loc_ok) begin
      case (reg_sel)
        SEL_ENABLE: rd_word = en_all[reg_loc];
        SEL_VECTOR: rd_word = REG_W'(VEC_NUM);
        SEL_STATUS: rd_word = st_all[reg_loc];
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= reg_rd;
      if (reg_rd) rdata <= rd_word;
    end
  end
endmodule

// File: rtl/irqc_line.sv
module irqc_line (
  input  logic clk,
  input  logic rst,
  input  logic any_latch,
  input  logic drop,
  input  logic pol_low,
  output logic lvl_q,
  output logic pin_q
);
  logic lvl_nx;

  always_comb begin
    lvl_nx = lvl_q;
    if (any_latch)  lvl_nx = 1'b1;
    else if (drop)  lvl_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      pin_q <= 1'b1;
    end else begin
      lvl_q <= lvl_nx;
      pin_q <= pol_low ? ~lvl_nx : lvl_nx;
    end
  end
endmodule

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = $clog2(NUM_LOC),
  parameter int VEC_NUM = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic [LOC_W-1:0] evt_loc,
  input  logic [EVT_W-1:0] evt_bits,
  input  logic [LOC_W-1:0] active_loc,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [LOC_W-1:0] reg_loc,
  input  logic [1:0]       reg_sel,
  input  logic [3:0]       reg_be,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             reg_rvalid,
  output logic             irq_pin
);
  localparam logic [LOC_W:0] LOC_LIM = (LOC_W+1)'(NUM_LOC);

  logic [NUM_LOC-1:0][REG_W-1:0] en_all, st_all, en_nx_all;
  logic [NUM_LOC-1:0] en_wr_vec, st_wr_vec, latch_vec, zero_vec;
  logic [REG_W-1:0]   wmask;
  logic ev_ok, act_ok, any_latch, drop, pol_low, lvl_q;

  assign ev_ok  = evt_valid && ({1'b0, evt_loc} < LOC_LIM);
  assign act_ok = ({1'b0, active_loc} < LOC_LIM);

  irqc_regport #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VEC_NUM(VEC_NUM)) u_port (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_loc(reg_loc),
    .reg_sel(reg_sel), .reg_be(reg_be), .active_loc(active_loc),
    .en_all(en_all), .st_all(st_all), .en_wr_vec(en_wr_vec), .st_wr_vec(st_wr_vec),
    .wmask(wmask), .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_slot
    irqc_slot u_slot (
      .clk(clk), .rst(rst),
      .ev_hit(ev_ok && (evt_loc == LOC_W'(i))), .ev_bits(evt_bits),
      .en_wr(en_wr_vec[i]), .st_wr(st_wr_vec[i]), .wmask(wmask), .wdata(reg_wdata),
      .en_q(en_all[i]), .st_q(st_all[i]), .en_nx(en_nx_all[i]),
      .latched(latch_vec[i]), .st_nx_zero(zero_vec[i])
    );
  end

  assign any_latch = |latch_vec;
  assign drop      = |(st_wr_vec & zero_vec);
  assign pol_low   = act_ok ? en_nx_all[active_loc][POL_LSB] : 1'b1;

  irqc_line u_line (
    .clk(clk), .rst(rst), .any_latch(any_latch), .drop(drop),
    .pol_low(pol_low), .lvl_q(lvl_q), .pin_q(irq_pin)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3,
  parameter int VEC_NUM = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_valid,
  input logic [LOC_W-1:0] evt_loc,
  input logic [LOC_W-1:0] active_loc,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [LOC_W-1:0] reg_loc,
  input logic [1:0]       reg_sel,
  input logic [31:0]      reg_rdata,
  input logic             reg_rvalid,
  input logic             lvl
);
  localparam logic [LOC_W:0] LIM = (LOC_W+1)'(NUM_LOC);

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid); // R10
  AST_VECTOR_CONST: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel == 2'd1 && {1'b0, reg_loc} < LIM) |=> reg_rdata == 32'(VEC_NUM)); // R9
  AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl) |-> $past(evt_valid)); // R2
  AST_BAD_LOC_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !({1'b0, evt_loc} < LIM)) |=> !$rose(lvl)); // R3
  AST_FALL_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    $fell(lvl) |-> $past(reg_wr && reg_sel == 2'd2)); // R7
  AST_FOREIGN_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_loc != active_loc) |=> !$fell(lvl)); // R6
endmodule

bind loc_irq_ctrl irqc_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VEC_NUM(VEC_NUM)) u_chk (
  .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_loc(evt_loc),
  .active_loc(active_loc), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_loc(reg_loc),
  .reg_sel(reg_sel), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .lvl(lvl_q)
);

// File: tb/tb_loc_irq_ctrl.sv
module tb_loc_irq_ctrl;
  localparam int VEC = 10;

  logic clk = 0, rst = 1;
  logic evt_valid = 0; logic [2:0] evt_loc = 0; logic [7:0] evt_bits = 0;
  logic [2:0] active_loc = 3'd7;
  logic reg_rd = 0, reg_wr = 0; logic [2:0] reg_loc = 0; logic [1:0] reg_sel = 0;
  logic [3:0] reg_be = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata; logic reg_rvalid, irq_pin;

  int tests = 0, fails = 0, cyc = 0;
  string phase = "R1";

  loc_irq_ctrl #(.VEC_NUM(VEC)) dut (.*);

  always #4 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_en [5]; logic [31:0] m_st [5];
  logic m_lvl = 0, m_pin = 1, m_rv = 0; logic [31:0] m_rd = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < 5; i++) begin m_en[i] = 32'h8; m_st[i] = 0; end
      m_lvl = 0; m_pin = 1; m_rv = 0; m_rd = 0;
    end else begin
      logic [31:0] wm, s; logic latch, chk_drop, pol;
      m_rv = reg_rd;
      if (reg_rd) begin
        if (reg_loc >= 5) m_rd = 0;
        else if (reg_sel == 0) m_rd = m_en[reg_loc];
        else if (reg_sel == 1) m_rd = VEC;
        else if (reg_sel == 2) m_rd = m_st[reg_loc];
        else m_rd = 0;
      end
      s = 0;
      if (evt_valid && evt_loc < 5 && m_en[evt_loc][31])
        s = {24'd0, evt_bits} & m_en[evt_loc] & 32'h87;
      latch = (s != 0);
      wm = {{8{reg_be[3]}}, {8{reg_be[2]}}, {8{reg_be[1]}}, {8{reg_be[0]}}};
      chk_drop = 0;
      if (reg_wr && active_loc < 5 && reg_loc == active_loc) begin
        if (reg_sel == 0) m_en[reg_loc] = (m_en[reg_loc] & ~wm) | (reg_wdata & wm & 32'h8000_009F);
        if (reg_sel == 2) begin m_st[reg_loc] &= ~(reg_wdata & wm & 32'h87); chk_drop = 1; end
      end
      if (latch) m_st[evt_loc] |= s;
      if (latch) m_lvl = 1;
      else if (chk_drop && m_st[reg_loc] == 0) m_lvl = 0;
      pol = (active_loc < 5) ? m_en[active_loc][3] : 1'b1;
      m_pin = pol ? ~m_lvl : m_lvl;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      chk({phase, " pin"}, {31'd0, irq_pin}, {31'd0, m_pin});
      chk({phase, " rvalid"}, {31'd0, reg_rvalid}, {31'd0, m_rv});
      chk({phase, " rdata"}, reg_rdata, m_rd);
    end
  end

  task automatic drive(bit ev, int el, int eb, bit rd, bit wr, int rl, int sel, int be, logic [31:0] wd);
    @(negedge clk);
    evt_valid = ev; evt_loc = 3'(el); evt_bits = 8'(eb);
    reg_rd = rd; reg_wr = wr; reg_loc = 3'(rl); reg_sel = 2'(sel); reg_be = 4'(be); reg_wdata = wd;
    @(negedge clk);
    evt_valid = 0; reg_rd = 0; reg_wr = 0;
  endtask

  task automatic rd_chk(string tag, int l, int sel, logic [31:0] exp);
    drive(0, 0, 0, 1, 0, l, sel, 0, 0);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(int l, int sel, int be, logic [31:0] wd);
    drive(0, 0, 0, 0, 1, l, sel, be, wd);
  endtask

  task automatic ev(int l, int bits);
    drive(1, l, bits, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic pin_chk(string tag, bit exp);
    chk(tag, {31'd0, irq_pin}, {31'd0, exp});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    phase = "R1";
    rd_chk("R1 enable reset", 0, 0, 32'h8);
    rd_chk("R1 status reset", 3, 2, 32'h0);
    pin_chk("R1 pin idle", 1);

    phase = "R4"; active_loc = 0;
    wr(0, 0, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R4 keep mask", 0, 0, 32'h8000_009F);
    wr(0, 0, 4'h1, 32'h0);
    rd_chk("R4 lane0 only", 0, 0, 32'h8000_0000);
    wr(0, 0, 4'hF, 32'h8000_0087);
    rd_chk("R4 full write", 0, 0, 32'h8000_0087);
    pin_chk("R8 high polarity idle", 0);

    phase = "R2";
    ev(0, 8'h01);
    pin_chk("R2 line raised", 1);
    rd_chk("R2 status set", 0, 2, 32'h1);

    phase = "R5";
    wr(0, 2, 4'h2, 32'h0000_0101);
    rd_chk("R5 other lane no clear", 0, 2, 32'h1);

    phase = "R6";
    wr(1, 2, 4'hF, 32'hFF);
    rd_chk("R6 foreign status write", 0, 2, 32'h1);
    pin_chk("R6 line kept", 1);
    wr(1, 0, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R6 foreign enable write", 1, 0, 32'h8);

    phase = "R7";
    wr(0, 2, 4'h1, 32'h01);
    pin_chk("R7 drop on zero", 0);

    phase = "R3";
    ev(0, 8'h08);
    rd_chk("R3 unsupported bit", 0, 2, 32'h0);
    ev(6, 8'h01);
    pin_chk("R3 invalid locality", 0);
    ev(1, 8'h01);
    rd_chk("R3 global off loc1", 1, 2, 32'h0);
    wr(0, 0, 4'hF, 32'h0000_0087);
    ev(0, 8'h01);
    rd_chk("R3 global off loc0", 0, 2, 32'h0);
    wr(0, 0, 4'hF, 32'h8000_0087);

    phase = "R7";
    ev(0, 8'h03);
    wr(0, 2, 4'h1, 32'h01);
    rd_chk("R7 partial clear", 0, 2, 32'h2);
    pin_chk("R7 line stays", 1);
    wr(0, 2, 4'h1, 32'h02);
    pin_chk("R7 line drops", 0);
    ev(0, 8'h01);
    drive(1, 0, 8'h80, 0, 1, 0, 2, 4'h1, 32'h01);
    rd_chk("R7 collision status", 0, 2, 32'h80);
    pin_chk("R7 collision line high", 1);
    wr(0, 2, 4'h1, 32'h80);
    pin_chk("R7 final drop", 0);

    phase = "R10";
    ev(0, 8'h02);
    drive(0, 0, 0, 1, 1, 0, 2, 4'h1, 32'h02);
    chk("R10 read before write", reg_rdata, 32'h2);
    rd_chk("R10 read after write", 0, 2, 32'h0);

    phase = "R8";
    active_loc = 2; @(negedge clk);
    pin_chk("R8 low polarity idle", 1);
    active_loc = 7; @(negedge clk);
    pin_chk("R8 no owner idle", 1);
    active_loc = 0; @(negedge clk);
    ev(0, 8'h01);
    pin_chk("R8 high polarity active", 1);
    active_loc = 2; @(negedge clk);
    pin_chk("R8 low polarity active", 0);
    active_loc = 0;
    wr(0, 2, 4'hF, 32'hFF);
    pin_chk("R8 back to idle", 0);

    phase = "R9";
    rd_chk("R9 vector", 0, 1, VEC);
    wr(0, 1, 4'hF, 32'h0);
    rd_chk("R9 vector after write", 0, 1, VEC);
    rd_chk("R9 unused select", 0, 3, 32'h0);
    rd_chk("R9 invalid locality read", 6, 0, 32'h0);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule